// File: doc/BRIEF.md
# Byte-Masked Synchronous RAM with Address Hold

This block is a single-port synchronous memory. On every rising clock edge it takes in an address, a write enable, a read enable, a per-lane write mask and write data. The data word is split into equal lanes. Each mask bit gates the write of one lane, so a partial-word update needs no read-modify-write.

An address-stall input freezes the internal address register. While it is high, both reads and writes go to the address that was last captured, and the address input is ignored. The output path holds its value whenever the read enable is low. An optional second output register trades one cycle of latency for timing slack. The asynchronous clear zeroes the output-side registers only.

Parameters select the behaviour when a read and a write hit the same address in the same cycle:
- New data: enabled lanes show the incoming data. Masked lanes show either the stored lane or the incoming lane, whichever costs less.
- Old data: the word as it was before the write.

Top module: `bm_ram`

## Requirements
- R1: Address, write enable, read enable, mask and write data are taken at the rising edge. Read data appears on `rdata_o` after that edge when `OUT_REG`=0, and after the following edge when `OUT_REG`=1.
- R2: When `stall_i` is 1 at an edge, the address register keeps its value and that held address is used for both the write and the read at that edge.
- R3: Mask bit i gates data bits [i*LANE_W +: LANE_W]. With an 18-bit word and 9-bit lanes, mask 2'b01 writes bits 8:0 only and 2'b10 writes bits 17:9 only. Mask width is DATA_W/LANE_W, and LANE_W is one of 5, 8, 9 or 10.
- R4: Lanes whose mask bit is 0 during a write keep their stored contents.
- R5: With `USE_BE`=0 the mask input is ignored and every write updates all lanes.
- R6: When `re_i` is 0 at an edge, the value that edge would load into the read path is not updated, so `rdata_o` keeps the result of the most recent enabled read, including during writes.
- R7: With `RDW_MODE`=new data, a read that coincides with a write returns the written lanes. The masked lanes show the stored lane when `MASKED_KEEP`=1, or the write-data lane when `MASKED_KEEP`=0.
- R8: With `RDW_MODE`=old data, a read that coincides with a write returns the word as stored before that write.
- R9: `rst_ni` low clears `rdata_o` to zero at once, without waiting for a clock edge. It does not alter the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all operations on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous clear of the output registers |
| addr_i | input | ADDR_W | Word address |
| stall_i | input | 1 | Hold the previously captured address |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| be_i | input | LANES | Per-lane write mask, bit 0 = lowest lane |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data |

## Verification
The following properties are checked on every cycle:
- Address capture and the address freeze under stall.
- The immediate clear of the output while reset is low.
- The hold of `rdata_o` after any edge where the relevant read enable was low, with the `OUT_REG` pipeline delay taken into account.

The following behaviours are shown only by the bench scenarios, because they depend on array contents:
- Lane masking and preservation of masked lanes.
- The two same-address read/write policies and the masked-lane choice under new data.
- The survival of the array across a clear.
- Full-word writes when the mask is unused.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  typedef enum logic {
    RDW_NEW = 1'b0,
    RDW_OLD = 1'b1
  } rdw_e;

  function automatic bit lane_w_ok(int w);
    return (w == 5) || (w == 8) || (w == 9) || (w == 10);
  endfunction
endpackage

// File: rtl/bmr_addr_reg.sv
module bmr_addr_reg #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              stall_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic [ADDR_W-1:0] addr_q_o
);
  logic [ADDR_W-1:0] addr_q;

  // stalled edges reuse the held address for this access
  assign eff_addr_o = stall_i ? addr_q : addr_i;
  assign addr_q_o   = addr_q;

  always_ff @(posedge clk_i) begin
    addr_q <= eff_addr_o;
  end
endmodule

// File: rtl/bmr_lane_mem.sv
module bmr_lane_mem #(
  parameter int LANE_W = 9,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);
  logic [LANE_W-1:0] mem_q [DEPTH];

  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[addr_i] <= wdata_i;
  end
endmodule

// File: rtl/bmr_rd_path.sv
module bmr_rd_path #(
  parameter int DATA_W  = 18,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (re_i) rd_q <= word_i;
  end

  if (OUT_REG) begin : g_oreg
    logic [DATA_W-1:0] out_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_q <= '0;
      else         out_q <= rd_q;
    end
    assign rdata_o = out_q;
  end else begin : g_noreg
    assign rdata_o = rd_q;
  end
endmodule

// File: rtl/bm_ram.sv
module bm_ram
  import bmr_pkg::*;
#(
  parameter int   DATA_W      = 18,
  parameter int   LANE_W      = 9,
  parameter int   DEPTH       = 16,
  parameter bit   OUT_REG     = 1'b0,
  parameter rdw_e RDW_MODE    = RDW_NEW,
  parameter bit   MASKED_KEEP = 1'b1,
  parameter bit   USE_BE      = 1'b1,
  localparam int  LANES       = DATA_W / LANE_W,
  localparam int  ADDR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              stall_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam bit CFG_OK = lane_w_ok(LANE_W) && (LANES * LANE_W == DATA_W) && (LANES > 0);

  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  lane_wr;
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] rd_word;

  if (!CFG_OK) begin : g_cfg_bad
    initial $fatal(1, "bm_ram: LANE_W must be 5/8/9/10 and divide DATA_W");
  end

  bmr_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i     (clk_i),
    .stall_i   (stall_i),
    .addr_i    (addr_i),
    .eff_addr_o(eff_addr),
    .addr_q_o  (addr_q)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] wl;
    logic [LANE_W-1:0] ol;

    assign wl = wdata_i[i*LANE_W +: LANE_W];
    assign lane_wr[i] = we_i & (USE_BE ? be_i[i] : 1'b1);

    bmr_lane_mem #(.LANE_W(LANE_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
      .clk_i  (clk_i),
      .wr_i   (lane_wr[i]),
      .addr_i (eff_addr),
      .wdata_i(wl),
      .rdata_o(ol)
    );

    assign old_word[i*LANE_W +: LANE_W] = ol;

    if (RDW_MODE == RDW_NEW) begin : g_new
      // masked lane: stored value or don't-care (write data is cheapest)
      always_comb begin
        if (!we_i)           rd_word[i*LANE_W +: LANE_W] = ol;
        else if (lane_wr[i]) rd_word[i*LANE_W +: LANE_W] = wl;
        else                 rd_word[i*LANE_W +: LANE_W] = MASKED_KEEP ? ol : wl;
      end
    end else begin : g_old
      assign rd_word[i*LANE_W +: LANE_W] = ol;
    end
  end

  bmr_rd_path #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .re_i   (re_i),
    .word_i (rd_word),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/bm_ram_chk.sv
module bm_ram_chk #(
  parameter int DATA_W  = 18,
  parameter int ADDR_W  = 4,
  parameter bit OUT_REG = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] rdata_o
);
  logic [1:0] cyc;
  logic       re_d;
  logic       sel_re;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc  <= '0;
      re_d <= 1'b0;
    end else begin
      re_d <= re_i;
      if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end
  end

  assign sel_re = OUT_REG ? re_d : re_i;

  p_clear_zero_r9: assert property (@(posedge clk_i)
    !rst_ni |-> rdata_o == '0);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3 && !$past(sel_re)) |-> $stable(rdata_o));

  p_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc != 2'd0 && stall_i) |=> addr_q == $past(addr_q));

  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i |=> addr_q == $past(addr_i));
endmodule

bind bm_ram bm_ram_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .stall_i(stall_i),
  .re_i   (re_i),
  .addr_i (addr_i),
  .addr_q (addr_q),
  .rdata_o(rdata_o)
);

// File: tb/sim_bm_ram.sv
module sim_bm_ram;
  import bmr_pkg::*;

  typedef struct packed {
    logic        st;
    logic [3:0]  a;
    logic        we;
    logic        re;
    logic [1:0]  be;
    logic [17:0] wd;
    logic [17:0] ea;  // u0: new data, masked lane keeps stored
    logic [17:0] eb;  // u1: output register, old data
    logic [17:0] ec;  // u2: new data, masked lane shows write data
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd1, 1'b1, 1'b0, 2'b11, 18'h12345, 18'h00000, 18'h00000, 18'h00000},
    '{1'b0, 4'd2, 1'b1, 1'b0, 2'b11, 18'h2ABCD, 18'h00000, 18'h00000, 18'h00000},
    '{1'b0, 4'd1, 1'b0, 1'b1, 2'b00, 18'h00000, 18'h12345, 18'h00000, 18'h12345},
    '{1'b0, 4'd1, 1'b1, 1'b0, 2'b01, 18'h3FFFF, 18'h12345, 18'h12345, 18'h12345},
    '{1'b0, 4'd1, 1'b0, 1'b1, 2'b00, 18'h00000, 18'h123FF, 18'h12345, 18'h123FF},
    '{1'b1, 4'd2, 1'b1, 1'b1, 2'b10, 18'h00000, 18'h001FF, 18'h123FF, 18'h00000},
    '{1'b0, 4'd2, 1'b0, 1'b1, 2'b00, 18'h00000, 18'h2ABCD, 18'h123FF, 18'h2ABCD},
    '{1'b0, 4'd1, 1'b0, 1'b1, 2'b00, 18'h00000, 18'h001FF, 18'h2ABCD, 18'h001FF},
    '{1'b0, 4'd2, 1'b1, 1'b1, 2'b00, 18'h00000, 18'h2ABCD, 18'h001FF, 18'h00000},
    '{1'b0, 4'd2, 1'b0, 1'b1, 2'b00, 18'h00000, 18'h2ABCD, 18'h2ABCD, 18'h2ABCD}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [3:0]  addr = '0;
  logic        stall = 1'b0, we = 1'b0, re = 1'b0;
  logic [1:0]  be = '0;
  logic [17:0] wd = '0;
  logic [3:0]  addr3 = '0;
  logic        we3 = 1'b0, re3 = 1'b0;
  logic [17:0] wd3 = '0;
  logic [17:0] q0, q1, q2, q3;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bm_ram u0 (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .stall_i(stall), .we_i(we),
             .re_i(re), .be_i(be), .wdata_i(wd), .rdata_o(q0));
  bm_ram #(.OUT_REG(1'b1), .RDW_MODE(RDW_OLD)) u1 (.clk_i(clk), .rst_ni(rst_n),
             .addr_i(addr), .stall_i(stall), .we_i(we), .re_i(re), .be_i(be),
             .wdata_i(wd), .rdata_o(q1));
  bm_ram #(.MASKED_KEEP(1'b0)) u2 (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
             .stall_i(stall), .we_i(we), .re_i(re), .be_i(be), .wdata_i(wd), .rdata_o(q2));
  bm_ram #(.USE_BE(1'b0)) u3 (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr3),
             .stall_i(1'b0), .we_i(we3), .re_i(re3), .be_i(2'b00), .wdata_i(wd3), .rdata_o(q3));

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %05h expected %05h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int i);
    case (i)
      2:       return "R1 read after one edge";
      3:       return "R6 hold during write; R3 lane0-only write";
      4, 7:    return "R4 masked lane kept";
      5:       return "R2 stalled write/read; R7 new-data masked lane";
      8:       return "R7 all-masked write during read";
      default: return "R1 table step";
    endcase
  endfunction

  initial begin
    #2 rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset value u0", q0, '0);
    chk("R9 reset value u1", q1, '0);
    chk("R9 reset value u3", q3, '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      stall = VECS[i].st; addr = VECS[i].a; we = VECS[i].we;
      re = VECS[i].re; be = VECS[i].be; wd = VECS[i].wd;
      @(negedge clk);
      chk(tag_of(i), q0, VECS[i].ea);
      chk($sformatf("R8 R1 u1 old data, step %0d", i), q1, VECS[i].eb);
      chk($sformatf("R7 u2 masked lane shows write data, step %0d", i), q2, VECS[i].ec);
    end
    we = 1'b0; re = 1'b0; stall = 1'b0;
    // R9: clear between edges
    #3 rst_n = 1'b0;
    #1 chk("R9 async clear u0", q0, '0);
    chk("R9 async clear u1", q1, '0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    addr = 4'd2; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    chk("R9 array kept after clear", q0, 18'h2ABCD);
    // R5: mask tied low, full word still written
    addr3 = 4'd0; wd3 = 18'h15555; we3 = 1'b1;
    @(negedge clk);
    we3 = 1'b0; re3 = 1'b1;
    @(negedge clk);
    re3 = 1'b0;
    chk("R5 mask ignored", q3, 18'h15555);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule